// File: doc/BRIEF.md
# Exception Recognition and Vector Unit

This block sits beside a processor's fetch and memory-access stages and decides, every clock, whether an exception is taken and which one. It gathers requests from the two reset inputs, from the bus-error, machine-check and parity inputs, from an external interrupt input, a decrementer and a system-management request, and from data-side and instruction-side access-fault reports produced by the memory-management stage.

Requests split into three classes. Resets and machine checks are asynchronous and cannot be masked. External, decrementer and system-management requests are asynchronous but gated by an interrupt-enable bit. Access faults are synchronous and always precise. A fixed priority picks one winner per cycle. The block then registers a 20-bit vector offset with a one-cycle take strobe. When a data-access fault wins, the block also registers a 32-bit status word that records the fault reasons and the access direction. Taking any exception other than a system reset clears the enable bit, and software sets it again through a small write port.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `exc_take` is 0, `exc_vec` is 0, `dflt_status` is 0 and `ie_bit` is 0.
- R2: If `soft_rst_in` or `hard_rst_in` is high at a clock edge, then after that edge `exc_take` is 1 and `exc_vec` is 0x00100, whatever `ie_bit` is, and `ie_bit` keeps the value it would otherwise have.
- R3: A machine check (vector 0x00200) is requested by `bus_tea` while `bus_data_busy` is high, by `mchk_pin`, by `addr_perr` or by `data_perr`, whatever `ie_bit` is. `bus_tea` with `bus_data_busy` low requests nothing.
- R4: When several requests are present, the winner follows this order, highest first: system reset, machine check, instruction-access fault, data-access fault, external interrupt, system management, decrementer. Exactly one vector is produced per cycle.
- R5: `ext_irq` (vector 0x00500), `smi_irq` (vector 0x01400) and `dec_irq` (vector 0x00900) are taken only while `ie_bit` is 1. While `ie_bit` is 0 they produce no take.
- R6: Taking any exception other than a system reset sets `ie_bit` to 0 after the same edge. Otherwise, `ie_wr` high loads `ie_wdata` into `ie_bit`. When both happen in one cycle, the clear wins. Gating always uses the value of `ie_bit` before the edge.
- R7: When a data-access fault (`dflt_valid`) is taken, `dflt_status` is loaded as follows: bit 1 = `dflt_no_xlate`, bit 4 = `dflt_prot`, bit 5 = `dflt_wt_ext` OR `dflt_dseg`, bit 6 = `dflt_store` (1 store, 0 load), bit 11 = `dflt_extacc_off`. Every other bit is 0.
- R8: `dflt_status` changes only after an edge at which a data-access fault is taken. It holds when a data-access fault loses to a higher-priority request.
- R9: An instruction-access fault (vector 0x00400) is requested by `iflt_no_xlate` or `iflt_prot` and is not masked by `ie_bit`.
- R10: Results are registered. A request sampled at edge N shows at the outputs after edge N. In a cycle with no take, `exc_vec` is 0, so offset 0 is never paired with a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_in | input | 1 | Soft reset request |
| hard_rst_in | input | 1 | Hard reset request |
| bus_tea | input | 1 | Transfer error acknowledge from the bus |
| bus_data_busy | input | 1 | A data bus transaction is in progress |
| mchk_pin | input | 1 | Machine-check request pin |
| addr_perr | input | 1 | Address parity error |
| data_perr | input | 1 | Data parity error |
| ext_irq | input | 1 | External interrupt request (level) |
| dec_irq | input | 1 | Decrementer request |
| smi_irq | input | 1 | System-management interrupt request |
| dflt_valid | input | 1 | Data-access fault reported this cycle |
| dflt_no_xlate | input | 1 | Data fault reason: no translation found |
| dflt_prot | input | 1 | Data fault reason: protection violation |
| dflt_wt_ext | input | 1 | Data fault reason: external-control access to write-through memory |
| dflt_dseg | input | 1 | Data fault reason: load/store to a direct-store segment |
| dflt_store | input | 1 | Data fault access direction, 1 = store |
| dflt_extacc_off | input | 1 | Data fault reason: external-control access with its enable cleared |
| iflt_no_xlate | input | 1 | Instruction fetch address not translatable |
| iflt_prot | input | 1 | Instruction fetch denied by protection |
| ie_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ie_wdata | input | 1 | Value written to the interrupt-enable bit |
| exc_take | output | 1 | One-cycle strobe: an exception is taken |
| exc_vec | output | 20 | Vector offset of the taken exception |
| ie_bit | output | 1 | Current interrupt-enable bit |
| dflt_status | output | 32 | Captured data-fault status word |

## Verification
Every result in this block is due one edge after the inputs that cause it are sampled. The take strobe, the vector, the status word and the new enable bit all appear after the same edge, so there is no multi-cycle latency to track. The driver applies each stimulus just after a falling edge and pushes the expected values tagged with the cycle number at which they become due. The monitor compares them at the following falling edge, half a period after the registering edge, when all outputs are settled. For the enable bit, the bench keeps its own model of the bit, so that gating and clearing in back-to-back cycles are predicted from the old value, as R6 requires.

// File: rtl/exc_vu_pkg.sv
package exc_vu_pkg;

  localparam int VEC_W = 20;
  localparam int NSRC  = 7;

  // Source index equals priority rank: index 0 wins over everything.
  typedef enum logic [2:0] {
    SRC_SRST = 3'd0,
    SRC_MCHK = 3'd1,
    SRC_ISI  = 3'd2,
    SRC_DSI  = 3'd3,
    SRC_EXT  = 3'd4,
    SRC_SMI  = 3'd5,
    SRC_DEC  = 3'd6
  } exc_src_e;

  localparam logic [VEC_W-1:0] VEC_SRST = 20'h00100;
  localparam logic [VEC_W-1:0] VEC_MCHK = 20'h00200;
  localparam logic [VEC_W-1:0] VEC_DSI  = 20'h00300;
  localparam logic [VEC_W-1:0] VEC_ISI  = 20'h00400;
  localparam logic [VEC_W-1:0] VEC_EXT  = 20'h00500;

  // Bit positions inside the data-fault status word.
  localparam int STB_NOXL   = 1;
  localparam int STB_PROT   = 4;
  localparam int STB_DIRECT = 5;
  localparam int STB_STORE  = 6;
  localparam int STB_EXTOFF = 11;

endpackage

// File: rtl/exc_vu_req.sv
// Turns raw pins and fault reports into one request line per source and
// forms the data-fault status word that would be captured this cycle.
module exc_vu_req
  import exc_vu_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              soft_rst_in,
  input  logic              hard_rst_in,
  input  logic              bus_tea,
  input  logic              bus_data_busy,
  input  logic              mchk_pin,
  input  logic              addr_perr,
  input  logic              data_perr,
  input  logic              ext_irq,
  input  logic              dec_irq,
  input  logic              smi_irq,
  input  logic              dflt_valid,
  input  logic              dflt_no_xlate,
  input  logic              dflt_prot,
  input  logic              dflt_wt_ext,
  input  logic              dflt_dseg,
  input  logic              dflt_store,
  input  logic              dflt_extacc_off,
  input  logic              iflt_no_xlate,
  input  logic              iflt_prot,
  input  logic              ie,
  output logic [NSRC-1:0]   req,
  output logic [STAT_W-1:0] dstat
);

  logic nonmask_rst, nonmask_mchk;

  always_comb begin
    nonmask_rst  = soft_rst_in | hard_rst_in;
    nonmask_mchk = (bus_tea & bus_data_busy) | mchk_pin | addr_perr | data_perr;

    req            = '0;
    req[SRC_SRST]  = nonmask_rst;
    req[SRC_MCHK]  = nonmask_mchk;
    req[SRC_ISI]   = iflt_no_xlate | iflt_prot;
    req[SRC_DSI]   = dflt_valid;
    req[SRC_EXT]   = ext_irq & ie;
    req[SRC_SMI]   = smi_irq & ie;
    req[SRC_DEC]   = dec_irq & ie;
  end

  always_comb begin
    dstat             = '0;
    dstat[STB_NOXL]   = dflt_no_xlate;
    dstat[STB_PROT]   = dflt_prot;
    dstat[STB_DIRECT] = dflt_wt_ext | dflt_dseg;
    dstat[STB_STORE]  = dflt_store;
    dstat[STB_EXTOFF] = dflt_extacc_off;
  end

endmodule

// File: rtl/exc_vu_pick.sv
// Fixed-priority one-hot picker; bit 0 has the highest priority.
module exc_vu_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end

  assign any = seen[N];

endmodule

// File: rtl/exc_vu_ie.sv
// Interrupt-enable bit: software write, cleared when an exception is taken.
module exc_vu_ie (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  input  logic clr,
  output logic ie_q
);

  always_ff @(posedge clk) begin
    if (rst)       ie_q <= 1'b0;
    else if (clr)  ie_q <= 1'b0;
    else if (wr)   ie_q <= wdata;
  end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vu_pkg::*;
#(
  parameter int               STAT_W  = 32,
  parameter logic [VEC_W-1:0] SMI_VEC = 20'h01400,
  parameter logic [VEC_W-1:0] DEC_VEC = 20'h00900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_in,
  input  logic              hard_rst_in,
  input  logic              bus_tea,
  input  logic              bus_data_busy,
  input  logic              mchk_pin,
  input  logic              addr_perr,
  input  logic              data_perr,
  input  logic              ext_irq,
  input  logic              dec_irq,
  input  logic              smi_irq,
  input  logic              dflt_valid,
  input  logic              dflt_no_xlate,
  input  logic              dflt_prot,
  input  logic              dflt_wt_ext,
  input  logic              dflt_dseg,
  input  logic              dflt_store,
  input  logic              dflt_extacc_off,
  input  logic              iflt_no_xlate,
  input  logic              iflt_prot,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  output logic              exc_take,
  output logic [VEC_W-1:0]  exc_vec,
  output logic              ie_bit,
  output logic [STAT_W-1:0] dflt_status
);

  logic [NSRC-1:0]   req;
  logic [NSRC-1:0]   grant;
  logic              any_req;
  logic [STAT_W-1:0] dstat;
  logic [VEC_W-1:0]  vec_next;
  logic              clr_ie;

  function automatic logic [VEC_W-1:0] vec_for(input int idx);
    case (idx)
      int'(SRC_SRST): return VEC_SRST;
      int'(SRC_MCHK): return VEC_MCHK;
      int'(SRC_ISI):  return VEC_ISI;
      int'(SRC_DSI):  return VEC_DSI;
      int'(SRC_EXT):  return VEC_EXT;
      int'(SRC_SMI):  return SMI_VEC;
      default:        return DEC_VEC;
    endcase
  endfunction

  exc_vu_req #(.STAT_W(STAT_W)) u_req (
    .soft_rst_in     (soft_rst_in),
    .hard_rst_in     (hard_rst_in),
    .bus_tea         (bus_tea),
    .bus_data_busy   (bus_data_busy),
    .mchk_pin        (mchk_pin),
    .addr_perr       (addr_perr),
    .data_perr       (data_perr),
    .ext_irq         (ext_irq),
    .dec_irq         (dec_irq),
    .smi_irq         (smi_irq),
    .dflt_valid      (dflt_valid),
    .dflt_no_xlate   (dflt_no_xlate),
    .dflt_prot       (dflt_prot),
    .dflt_wt_ext     (dflt_wt_ext),
    .dflt_dseg       (dflt_dseg),
    .dflt_store      (dflt_store),
    .dflt_extacc_off (dflt_extacc_off),
    .iflt_no_xlate   (iflt_no_xlate),
    .iflt_prot       (iflt_prot),
    .ie              (ie_bit),
    .req             (req),
    .dstat           (dstat)
  );

  exc_vu_pick #(.N(NSRC)) u_pick (
    .req   (req),
    .grant (grant),
    .any   (any_req)
  );

  // Any taken exception except system reset closes the maskable gate.
  assign clr_ie = any_req & ~grant[SRC_SRST];

  exc_vu_ie u_ie (
    .clk   (clk),
    .rst   (rst),
    .wr    (ie_wr),
    .wdata (ie_wdata),
    .clr   (clr_ie),
    .ie_q  (ie_bit)
  );

  always_comb begin
    vec_next = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) vec_next = vec_next | vec_for(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_take    <= 1'b0;
      exc_vec     <= '0;
      dflt_status <= '0;
    end else begin
      exc_take <= any_req;
      exc_vec  <= vec_next;
      if (grant[SRC_DSI]) dflt_status <= dstat;
    end
  end

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_vu_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst_in,
  input logic              hard_rst_in,
  input logic              bus_tea,
  input logic              bus_data_busy,
  input logic              mchk_pin,
  input logic              addr_perr,
  input logic              data_perr,
  input logic              dflt_valid,
  input logic              iflt_no_xlate,
  input logic              iflt_prot,
  input logic              exc_take,
  input logic [VEC_W-1:0]  exc_vec,
  input logic              ie_bit,
  input logic [STAT_W-1:0] dflt_status
);

  logic any_rst, any_mchk, any_ifault;
  logic [STAT_W-1:0] used_bits;

  always_comb begin
    any_rst    = soft_rst_in | hard_rst_in;
    any_mchk   = (bus_tea & bus_data_busy) | mchk_pin | addr_perr | data_perr;
    any_ifault = iflt_no_xlate | iflt_prot;
    used_bits  = '0;
    used_bits[STB_NOXL]   = 1'b1;
    used_bits[STB_PROT]   = 1'b1;
    used_bits[STB_DIRECT] = 1'b1;
    used_bits[STB_STORE]  = 1'b1;
    used_bits[STB_EXTOFF] = 1'b1;
  end

  a_r2_sysrst_vec: assert property (@(posedge clk) disable iff (rst)
    any_rst |=> (exc_take && exc_vec == VEC_SRST));

  a_r3_mchk_unmasked: assert property (@(posedge clk) disable iff (rst)
    (!any_rst && any_mchk) |=> (exc_take && exc_vec == VEC_MCHK));

  a_r9_ifault_vec: assert property (@(posedge clk) disable iff (rst)
    (!any_rst && !any_mchk && any_ifault) |=> (exc_take && exc_vec == VEC_ISI));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ie_bit && !any_rst && !any_mchk && !any_ifault && !dflt_valid) |=> !exc_take);

  a_r6_ie_cleared: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exc_vec != VEC_SRST) |-> !ie_bit);

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (dflt_status & ~used_bits) == '0);

  a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
    !(exc_take && exc_vec == VEC_DSI) |-> $stable(dflt_status));

  a_r10_idle_vec_zero: assert property (@(posedge clk) disable iff (rst)
    !exc_take |-> exc_vec == '0);

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.STAT_W(STAT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .soft_rst_in   (soft_rst_in),
  .hard_rst_in   (hard_rst_in),
  .bus_tea       (bus_tea),
  .bus_data_busy (bus_data_busy),
  .mchk_pin      (mchk_pin),
  .addr_perr     (addr_perr),
  .data_perr     (data_perr),
  .dflt_valid    (dflt_valid),
  .iflt_no_xlate (iflt_no_xlate),
  .iflt_prot     (iflt_prot),
  .exc_take      (exc_take),
  .exc_vec       (exc_vec),
  .ie_bit        (ie_bit),
  .dflt_status   (dflt_status)
);

// File: tb/tb_exc_vector_unit.sv
`timescale 1ns/1ps
module tb_exc_vector_unit;

  // Stimulus bit positions
  localparam int P_SOFT = 0,  P_HARD = 1,  P_TEA = 2,   P_BUSY = 3,  P_MCP = 4;
  localparam int P_APE  = 5,  P_DPE  = 6,  P_EXT = 7,   P_DEC  = 8,  P_SMI = 9;
  localparam int P_DF   = 10, P_DNX  = 11, P_DPR = 12,  P_DWT  = 13, P_DDS = 14;
  localparam int P_DST  = 15, P_DEO  = 16, P_INX = 17,  P_IPR  = 18, P_WR  = 19;
  localparam int P_WD   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [20:0] stim = '0;

  logic        exc_take;
  logic [19:0] exc_vec;
  logic        ie_bit;
  logic [31:0] dflt_status;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          due;
    logic        take;
    logic [19:0] vec;
    logic        ie;
    logic [31:0] stat;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  logic        m_ie   = 1'b0;
  logic [31:0] m_stat = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exc_vector_unit dut (
    .clk(clk), .rst(rst),
    .soft_rst_in(stim[P_SOFT]), .hard_rst_in(stim[P_HARD]),
    .bus_tea(stim[P_TEA]), .bus_data_busy(stim[P_BUSY]),
    .mchk_pin(stim[P_MCP]), .addr_perr(stim[P_APE]), .data_perr(stim[P_DPE]),
    .ext_irq(stim[P_EXT]), .dec_irq(stim[P_DEC]), .smi_irq(stim[P_SMI]),
    .dflt_valid(stim[P_DF]), .dflt_no_xlate(stim[P_DNX]), .dflt_prot(stim[P_DPR]),
    .dflt_wt_ext(stim[P_DWT]), .dflt_dseg(stim[P_DDS]), .dflt_store(stim[P_DST]),
    .dflt_extacc_off(stim[P_DEO]),
    .iflt_no_xlate(stim[P_INX]), .iflt_prot(stim[P_IPR]),
    .ie_wr(stim[P_WR]), .ie_wdata(stim[P_WD]),
    .exc_take(exc_take), .exc_vec(exc_vec), .ie_bit(ie_bit), .dflt_status(dflt_status)
  );

  function automatic logic [20:0] b(input int p);
    return 21'(1) << p;
  endfunction

  // Driver: apply one cycle of stimulus, predict, push, advance.
  task automatic step(input logic [20:0] s, input string tag);
    exp_t e;
    logic r_rst, r_mc, r_isi;
    stim  = s;
    r_rst = s[P_SOFT] | s[P_HARD];
    r_mc  = (s[P_TEA] & s[P_BUSY]) | s[P_MCP] | s[P_APE] | s[P_DPE];
    r_isi = s[P_INX] | s[P_IPR];
    e.take = 1'b1;
    if (r_rst)                 e.vec = 20'h00100;
    else if (r_mc)             e.vec = 20'h00200;
    else if (r_isi)            e.vec = 20'h00400;
    else if (s[P_DF])          e.vec = 20'h00300;
    else if (s[P_EXT] && m_ie) e.vec = 20'h00500;
    else if (s[P_SMI] && m_ie) e.vec = 20'h01400;
    else if (s[P_DEC] && m_ie) e.vec = 20'h00900;
    else begin e.take = 1'b0; e.vec = 20'h0; end
    if (e.vec == 20'h00300) begin
      m_stat     = '0;
      m_stat[1]  = s[P_DNX];
      m_stat[4]  = s[P_DPR];
      m_stat[5]  = s[P_DWT] | s[P_DDS];
      m_stat[6]  = s[P_DST];
      m_stat[11] = s[P_DEO];
    end
    if (e.take && e.vec != 20'h00100) m_ie = 1'b0;
    else if (s[P_WR])                 m_ie = s[P_WD];
    e.ie   = m_ie;
    e.stat = m_stat;
    e.due  = cyc + 1;
    e.tag  = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare due items half a period after the registering edge.
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      total++;
      if (exc_take !== e.take || exc_vec !== e.vec || ie_bit !== e.ie ||
          dflt_status !== e.stat) begin
        bad++;
        $display("FAIL %s: take=%0b vec=%05h ie=%0b stat=%08h expected take=%0b vec=%05h ie=%0b stat=%08h",
                 e.tag, exc_take, exc_vec, ie_bit, dflt_status,
                 e.take, e.vec, e.ie, e.stat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values visible right after release
    total++;
    if (exc_take !== 1'b0 || exc_vec !== 20'h0 || ie_bit !== 1'b0 || dflt_status !== 32'h0) begin
      bad++;
      $display("FAIL R1 reset state: take=%0b vec=%05h ie=%0b stat=%08h expected all zero",
               exc_take, exc_vec, ie_bit, dflt_status);
    end
    step('0, "R1 idle after reset");
    step('0, "R10 idle vector zero");
    // Maskable sources with enable low
    step(b(P_EXT), "R5 ext blocked while ie=0");
    step(b(P_DEC) | b(P_SMI), "R5 dec/smi blocked while ie=0");
    // R6: write and gating by the old value
    step(b(P_EXT) | b(P_WR) | b(P_WD), "R6 write uses old ie for gating");
    step(b(P_EXT), "R5 ext taken, R6 ie cleared");
    step(b(P_EXT), "R5 held ext blocked after clear");
    step(b(P_WR) | b(P_WD), "R6 ie write");
    step(b(P_DEC), "R5 decrementer vector");
    step(b(P_WR) | b(P_WD), "R6 ie write");
    step(b(P_SMI), "R5 smi vector");
    step(b(P_WR) | b(P_WD), "R6 ie write");
    step(b(P_SMI) | b(P_DEC), "R4 smi over dec");
    step(b(P_WR) | b(P_WD), "R6 ie write");
    step(b(P_EXT) | b(P_SMI) | b(P_DEC), "R4 ext over smi and dec");
    step(b(P_WR) | b(P_WD), "R6 ie write");
    // R2: system reset keeps ie
    step(b(P_SOFT), "R2 soft reset vector, ie kept");
    step(b(P_HARD) | b(P_EXT), "R2 hard reset over ext");
    // R3: machine check sources
    step(b(P_TEA), "R3 tea without bus activity ignored");
    step(b(P_TEA) | b(P_BUSY), "R3 tea during bus transfer");
    step(b(P_MCP), "R3 machine check pin with ie=0");
    step(b(P_APE), "R3 address parity");
    step(b(P_DPE), "R3 data parity");
    // R9: instruction fault
    step(b(P_INX), "R9 ifetch no translation");
    step(b(P_IPR), "R9 ifetch protection");
    // R7: status composition
    step(b(P_DF) | b(P_DNX) | b(P_DST), "R7 no-xlate store");
    step(b(P_DF) | b(P_DPR), "R7 protection load");
    step(b(P_DF) | b(P_DWT), "R7 write-through external access");
    step(b(P_DF) | b(P_DDS) | b(P_DEO), "R7 direct-store and ext-access off");
    step(b(P_DF) | b(P_DNX) | b(P_DPR) | b(P_DWT) | b(P_DST) | b(P_DEO), "R7 all reasons");
    // R8: status holds when data fault loses
    step(b(P_DF) | b(P_DPR) | b(P_INX), "R8 dfault loses to ifault, status held");
    step(b(P_DF) | b(P_DST) | b(P_MCP) | b(P_INX), "R4 mchk over ifault and dfault");
    step(b(P_SOFT) | b(P_MCP) | b(P_DF), "R4 reset over mchk, R8 hold");
    step(b(P_DF) | b(P_WR) | b(P_WD), "R6 clear wins over write");
    step(b(P_EXT), "R6 ext blocked after clear beat write");
    step('0, "R10 idle after sequence");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule